// File: doc/BRIEF.md
# Standard Event Status Register

This block holds an instrument's standard event status byte. It latches single-cycle event pulses into fixed bit positions and pairs them with a writable enable mask. Each latched bit stays set until a read access clears the whole byte. When any latched event is also enabled, the block raises a summary output. The parent status byte uses that output as its event-summary input.

Next to the byte, a two-bit code register records the kind of the most recent query error. The command parser, the executor and the reply path drive the strobes. They fetch the byte, the mask and the code through plain read and write strobes. The read data is always visible, and a read strobe marks that the current value has been consumed.

Top module: `evstat_top`

## Requirements
- R1: After reset the event byte reads 0x80 (power-on flag in bit 7), the mask reads 0x00, the query code reads 0 and the summary is low.
- R2: A pulse on `cmd_err_i` sets bit 5 of the event byte from the next cycle on.
- R3: A pulse on `exec_err_i` sets bit 4 of the event byte from the next cycle on.
- R4: A pulse on `qry_err_i` sets bit 2 of the event byte and stores `qry_code_i` in the code register from the next cycle on (1 = interrupted, 2 = deadlock, 3 = unterminated).
- R5: A pulse on `op_done_i` sets bit 0 of the event byte from the next cycle on.
- R6: Bits 6, 3 and 1 of the event byte always read 0.
- R7: `evt_data_o` shows the current byte in the cycle that `evt_rd_i` is high. From the next cycle all bits are 0, the power-on bit included.
- R8: An event pulse in the same cycle as `evt_rd_i` is not seen by that read, and its bit is set after the clear.
- R9: `mask_wr_i` loads `mask_wdata_i` into the mask in the next cycle. All 8 bits read back unchanged on `mask_data_o`, and the mask holds while no write occurs.
- R10: `summary_o` is high exactly when the event byte ANDed with the mask is nonzero. Mask bits 6, 3 and 1 therefore never raise it.
- R11: The code register keeps its value until a `code_rd_i` pulse clears it to 0 in the next cycle. A query error in the same cycle as that pulse leaves the new code stored.
- R12: Latched event bits accumulate and stay set until a read clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_err_i | input | 1 | Syntax error pulse from the parser |
| exec_err_i | input | 1 | Execution failure pulse |
| qry_err_i | input | 1 | Query error pulse |
| qry_code_i | input | 2 | Kind of query error, valid with `qry_err_i` |
| op_done_i | input | 1 | Operation-complete command pulse |
| evt_rd_i | input | 1 | Read-and-clear strobe for the event byte |
| evt_data_o | output | 8 | Current event byte |
| mask_wr_i | input | 1 | Enable mask write strobe |
| mask_wdata_i | input | 8 | Enable mask write data |
| mask_data_o | output | 8 | Enable mask read data |
| code_rd_i | input | 1 | Read-and-clear strobe for the query code |
| code_o | output | 2 | Current query error code |
| summary_o | output | 1 | High when an enabled event is latched |

## Verification
Two functions can fall in the same cycle: a read-and-clear and a new event, both for the event byte and for the query code. The bench raises the read strobe and an event pulse together. Before the clock edge it checks that the read data still holds the old byte. After the edge it checks that only the new event's bit, or the new code, is left. The summary output is re-checked in the same steps, so a lost or doubled event also shows up there.

// File: rtl/evstat_pkg.sv
package evstat_pkg;
    parameter int EVT_W  = 8;
    parameter int CODE_W = 2;

    localparam int BIT_PWR  = 7;
    localparam int BIT_CMD  = 5;
    localparam int BIT_EXEC = 4;
    localparam int BIT_QRY  = 2;
    localparam int BIT_OPC  = 0;

    localparam logic [EVT_W-1:0] USED_MASK =
        (EVT_W'(1) << BIT_PWR) | (EVT_W'(1) << BIT_CMD) |
        (EVT_W'(1) << BIT_EXEC) | (EVT_W'(1) << BIT_QRY) |
        (EVT_W'(1) << BIT_OPC);
    localparam logic [EVT_W-1:0] RESET_EVT = EVT_W'(1) << BIT_PWR;

    typedef struct packed {
        logic [EVT_W-1:0] bits;
    } evt_state_t;

    typedef struct packed {
        logic [EVT_W-1:0] bits;
    } mask_state_t;

    typedef struct packed {
        logic [CODE_W-1:0] code;
    } code_state_t;
endpackage

// File: rtl/evstat_event_reg.sv
module evstat_event_reg
    import evstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EVT_W-1:0] set_i,
    input  logic             clr_i,
    output logic [EVT_W-1:0] evt_o
);
    evt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < EVT_W; i++) begin
            if (USED_MASK[i]) begin
                st_d.bits[i] = set_i[i] | (st_q.bits[i] & ~clr_i);
            end else begin
                st_d.bits[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{bits: RESET_EVT};
        else        st_q <= st_d;
    end

    assign evt_o = st_q.bits;

    assert_unused_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o & ~USED_MASK) == '0);
    assert_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> ((evt_o & $past(evt_o)) == $past(evt_o)));
    assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && set_i == '0) |=> evt_o == '0);
    assert_read_keep_new_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && (set_i & USED_MASK) != '0) |=> evt_o != '0);
endmodule

// File: rtl/evstat_mask_reg.sv
module evstat_mask_reg
    import evstat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [EVT_W-1:0] wdata_i,
    output logic [EVT_W-1:0] mask_o
);
    mask_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_i) st_d.bits = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask_o = st_q.bits;

    assert_mask_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> mask_o == $past(wdata_i));
    assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o));
endmodule

// File: rtl/evstat_code_reg.sv
module evstat_code_reg
    import evstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              clr_i,
    output logic [CODE_W-1:0] code_o
);
    code_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)      st_d.code = code_i;
        else if (clr_i) st_d.code = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o = st_q.code;

    assert_code_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> code_o == $past(code_i));
    assert_code_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> code_o == '0);
    assert_code_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(code_o));
endmodule

// File: rtl/evstat_top.sv
module evstat_top
    import evstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_err_i,
    input  logic              exec_err_i,
    input  logic              qry_err_i,
    input  logic [CODE_W-1:0] qry_code_i,
    input  logic              op_done_i,
    input  logic              evt_rd_i,
    output logic [EVT_W-1:0]  evt_data_o,
    input  logic              mask_wr_i,
    input  logic [EVT_W-1:0]  mask_wdata_i,
    output logic [EVT_W-1:0]  mask_data_o,
    input  logic              code_rd_i,
    output logic [CODE_W-1:0] code_o,
    output logic              summary_o
);
    logic [EVT_W-1:0] set_vec;

    always_comb begin
        set_vec           = '0;
        set_vec[BIT_CMD]  = cmd_err_i;
        set_vec[BIT_EXEC] = exec_err_i;
        set_vec[BIT_QRY]  = qry_err_i;
        set_vec[BIT_OPC]  = op_done_i;
    end

    evstat_event_reg u_evt (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (evt_rd_i),
        .evt_o (evt_data_o)
    );

    evstat_mask_reg u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mask_wr_i),
        .wdata_i (mask_wdata_i),
        .mask_o  (mask_data_o)
    );

    evstat_code_reg u_code (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (qry_err_i),
        .code_i (qry_code_i),
        .clr_i  (code_rd_i),
        .code_o (code_o)
    );

    assign summary_o = |(evt_data_o & mask_data_o & USED_MASK);

    assert_summary_needs_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
        summary_o |-> (evt_data_o != '0 && mask_data_o != '0));
    assert_cmd_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err_i |=> evt_data_o[BIT_CMD]);
    assert_exec_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        exec_err_i |=> evt_data_o[BIT_EXEC]);
    assert_opc_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        op_done_i |=> evt_data_o[BIT_OPC]);
endmodule

// File: tb/evstat_top_tb.sv
module evstat_top_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_err_i = 0, exec_err_i = 0, qry_err_i = 0, op_done_i = 0;
    logic [1:0] qry_code_i = 0;
    logic       evt_rd_i = 0, mask_wr_i = 0, code_rd_i = 0;
    logic [7:0] mask_wdata_i = 0;
    logic [7:0] evt_data_o, mask_data_o;
    logic [1:0] code_o;
    logic       summary_o;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    evstat_top u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_err_i(cmd_err_i), .exec_err_i(exec_err_i),
        .qry_err_i(qry_err_i), .qry_code_i(qry_code_i), .op_done_i(op_done_i),
        .evt_rd_i(evt_rd_i), .evt_data_o(evt_data_o), .mask_wr_i(mask_wr_i),
        .mask_wdata_i(mask_wdata_i), .mask_data_o(mask_data_o),
        .code_rd_i(code_rd_i), .code_o(code_o), .summary_o(summary_o)
    );

    typedef struct packed {
        logic       cmd;
        logic       exec;
        logic       qry;
        logic [1:0] code;
        logic       opc;
        logic       erd;
        logic       mwr;
        logic [7:0] mdat;
        logic       crd;
        logic [7:0] x_evt;
        logic [7:0] x_mask;
        logic [1:0] x_code;
        logic       x_sum;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{0,0,0,2'd0,0,0,1,8'hFF,0, 8'h80,8'hFF,2'd0,1, 8'd10},
        '{0,0,0,2'd0,0,1,0,8'h00,0, 8'h00,8'hFF,2'd0,0, 8'd7 },
        '{1,0,0,2'd0,0,0,0,8'h00,0, 8'h20,8'hFF,2'd0,1, 8'd2 },
        '{0,1,0,2'd0,0,0,0,8'h00,0, 8'h30,8'hFF,2'd0,1, 8'd3 },
        '{0,0,1,2'd2,0,0,0,8'h00,0, 8'h34,8'hFF,2'd2,1, 8'd4 },
        '{0,0,0,2'd0,1,0,0,8'h00,0, 8'h35,8'hFF,2'd2,1, 8'd5 },
        '{0,0,0,2'd0,0,0,1,8'h4A,0, 8'h35,8'h4A,2'd2,0, 8'd10},
        '{0,0,0,2'd0,0,0,1,8'h01,0, 8'h35,8'h01,2'd2,1, 8'd9 },
        '{0,0,0,2'd0,0,0,0,8'h00,1, 8'h35,8'h01,2'd0,1, 8'd11},
        '{0,0,1,2'd3,0,1,0,8'h00,0, 8'h04,8'h01,2'd3,0, 8'd8 },
        '{0,0,1,2'd1,0,0,0,8'h00,1, 8'h04,8'h01,2'd1,0, 8'd11},
        '{0,0,0,2'd0,0,1,0,8'h00,0, 8'h00,8'h01,2'd1,0, 8'd12},
        '{0,0,1,2'd3,0,0,1,8'h04,0, 8'h04,8'h04,2'd3,1, 8'd4 }
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        cmd_err_i = 0; exec_err_i = 0; qry_err_i = 0; qry_code_i = 0;
        op_done_i = 0; evt_rd_i = 0; mask_wr_i = 0; mask_wdata_i = 0; code_rd_i = 0;
    endtask

    initial begin
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        chk("R1 evt", evt_data_o, 8'h80);
        chk("R1 mask", mask_data_o, 8'h00);
        chk("R1 code", {6'd0, code_o}, 8'h00);
        chk("R1 sum", {7'd0, summary_o}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            cmd_err_i = v.cmd; exec_err_i = v.exec; qry_err_i = v.qry;
            qry_code_i = v.code; op_done_i = v.opc; evt_rd_i = v.erd;
            mask_wr_i = v.mwr; mask_wdata_i = v.mdat; code_rd_i = v.crd;
            @(negedge clk);
            idle();
            chk($sformatf("R%0d evt v%0d", v.req, i), evt_data_o, v.x_evt);
            chk($sformatf("R%0d mask v%0d", v.req, i), mask_data_o, v.x_mask);
            chk($sformatf("R%0d code v%0d", v.req, i), {6'd0, code_o}, {6'd0, v.x_code});
            chk($sformatf("R%0d sum v%0d", v.req, i), {7'd0, summary_o}, {7'd0, v.x_sum});
        end

        // R8 / R7: read coincides with event, data seen before the edge
        evt_rd_i = 1; op_done_i = 1;
        #1;
        chk("R7 read data before clear", evt_data_o, 8'h04);
        @(negedge clk);
        idle();
        chk("R8 new event kept after clear", evt_data_o, 8'h01);

        // R6: all strobes together, unused bits stay zero
        cmd_err_i = 1; exec_err_i = 1; qry_err_i = 1; qry_code_i = 2'd1; op_done_i = 1;
        @(negedge clk);
        idle();
        chk("R6 unused bits", evt_data_o & 8'h4A, 8'h00);
        chk("R12 all events", evt_data_o, 8'h35);

        // R7 power-on bit cleared by read; then R1 on re-reset
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk("R1 re-reset evt", evt_data_o, 8'h80);
        evt_rd_i = 1;
        @(negedge clk);
        idle();
        chk("R7 power-on cleared", evt_data_o, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule